// File: doc/BRIEF.md
# Flash Bulk Erase Sequencer

This block runs a complete chip-erase procedure on a byte-wide parallel flash device, with no help from the host beyond a start pulse. The procedure has three phases. First it programs every byte to zero, so that all cells carry the same charge before the erase. It then issues the two-write erase command and holds the erase pulse for a set number of cycles. Finally it checks the array one byte at a time with erase-verify commands.

When a byte reads back as anything other than all ones, the sequencer erases the whole chip again. It then picks up verification at that same byte, not at address zero. A limit on the total number of erase pulses protects a worn device. If the limit is reached while a byte still fails, the run ends with an error flag.

The programming-voltage enable is held high for the whole run and dropped when the run ends. The host sees only `start_i`, `done_o` and `err_o`. The device side is a plain strobed bus: chip enable, write enable and output enable, all active low, plus an address bus, a write-data bus and a read-data bus. There is no streaming data path, so no valid/ready handshake exists. Every pin is a plain level.

Top module: `bulk_erase_seq`

## Requirements
- R1: After a start, the sequencer writes the program command 40h and then the data byte 00h to every address. It does this in ascending address order from 0 to the last address, waits at least PROG_CYC cycles after each byte, and issues no erase command until the last byte is done.
- R2: An erase is two consecutive writes of 20h. The first erase after pre-programming is issued at address 0, and every erase counts as one erase pulse.
- R3: After the second 20h write, at least ERASE_CYC clock cycles pass before the next command write ends the erase pulse.
- R4: Each byte check is a write of A0h carrying the byte's address. At least VERIFY_CYC cycles then pass before the read strobe (OE low), and only a read value of FFh counts as erased.
- R5: When a verify read is not FFh and fewer than MAX_PULSES erase pulses have been issued, the sequencer issues a new two-write erase. The next A0h write after that erase uses the same failing address.
- R6: Once the last address reads FFh, the sequencer writes 00h to leave verify mode. It then sets `done_o` with `err_o` low and drops `vpp_en_o`. An accepted start clears both `done_o` and `err_o` one cycle later.
- R7: A failed verify after MAX_PULSES erase pulses ends the run with `done_o` and `err_o` both high and `vpp_en_o` low, and no further device write follows. The pulse count never exceeds MAX_PULSES.
- R8: `vpp_en_o` is high from the cycle after an accepted start until the run ends, and every write strobe occurs while it is high.
- R9: The bus rules are as follows. WE# is low only while CE# is low and OE# is high. OE# is low only while CE# is low and WE# is high. Address and write data stay unchanged while WE# is low.
- R10: After reset, CE#, WE# and OE# are high, and `done_o`, `err_o` and `vpp_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run when idle; ignored while busy |
| done_o | output | 1 | Run ended; held until the next accepted start |
| err_o | output | 1 | Run ended at the pulse limit; held with done_o |
| vpp_en_o | output | 1 | Programming-voltage enable |
| dev_addr_o | output | ADDR_W | Device byte address |
| dev_dq_o | output | 8 | Device write data / command |
| dev_dq_i | input | 8 | Device read data |
| dev_ce_n_o | output | 1 | Chip enable, active low |
| dev_we_n_o | output | 1 | Write enable, active low; commands latch on its rising edge |
| dev_oe_n_o | output | 1 | Output enable, active low |

## Verification
The bound checker watches the bus strobe rules, address and data stability during a write, and voltage-enable coverage of every write, on every cycle. It also checks that the pulse counter stays within its limit, that an error always comes with done, and that an accepted start clears status. The ordering of the command stream can only be shown by the bench's scenarios, using a behavioural flash model whose bytes need different numbers of erase pulses. Those scenarios cover pre-programming, the resume-at-failing-address rule, the minimum pulse and settle windows, and the outcome at the pulse limit.

// File: rtl/bes_pkg.sv
package bes_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PP_CMD, S_PP_DATA, S_PP_WAIT,
    S_ER_SETUP, S_ER_GO, S_ER_WAIT,
    S_VF_CMD, S_VF_WAIT, S_VF_READ, S_EXIT
  } seq_state_e;

  typedef enum logic [1:0] {
    B_IDLE, B_SETUP, B_STROBE, B_HOLD
  } bus_state_e;

  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_VERIFY  = 8'hA0;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] DATA_ZERO   = 8'h00;
  localparam logic [7:0] DATA_ERASED = 8'hFF;

endpackage

// File: rtl/bes_bus_port.sv
// Runs one strobed device cycle per request: setup, strobe, hold.
module bes_bus_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              ack,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [7:0]        dev_dq_o,
  input  logic [7:0]        dev_dq_i,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n
);
  import bes_pkg::*;

  bus_state_e        st;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [7:0]        rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= B_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st)
        B_IDLE: if (req) begin
          st     <= B_SETUP;
          rd_q   <= rd;
          addr_q <= addr;
          data_q <= wdata;
        end
        B_SETUP: st <= B_STROBE;
        B_STROBE: begin
          if (rd_q) rdata_q <= dev_dq_i;
          st <= B_HOLD;
        end
        B_HOLD: st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign ce_n     = (st == B_IDLE);
  assign we_n     = !((st == B_STROBE) && !rd_q);
  assign oe_n     = !(((st == B_SETUP) || (st == B_STROBE)) && rd_q);
  assign ack      = (st == B_HOLD);
  assign rdata    = rdata_q;
  assign dev_addr = addr_q;
  assign dev_dq_o = data_q;

endmodule

// File: rtl/bes_timer.sv
// Loadable down-counter shared by the three wait phases.
module bes_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq #(
  parameter int ADDR_W     = 8,
  parameter int PROG_CYC   = 10,
  parameter int ERASE_CYC  = 200,
  parameter int VERIFY_CYC = 6,
  parameter int MAX_PULSES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic              vpp_en_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [7:0]        dev_dq_o,
  input  logic [7:0]        dev_dq_i,
  output logic              dev_ce_n_o,
  output logic              dev_we_n_o,
  output logic              dev_oe_n_o
);
  import bes_pkg::*;

  localparam int TMAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMAX   = (TMAX_A > VERIFY_CYC) ? TMAX_A : VERIFY_CYC;
  localparam int TW     = $clog2(TMAX + 2);
  localparam int PW     = $clog2(MAX_PULSES + 2);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [PW-1:0]     pulse_q;
  logic              vpp_q, done_q, err_q;
  logic              busy;

  logic              bus_req, bus_rd, bus_ack;
  logic [7:0]        bus_wdata, bus_rdata;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;

  assign busy = (st != S_IDLE);

  bes_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk, .rst_n,
    .req(bus_req), .rd(bus_rd), .addr(addr_q), .wdata(bus_wdata),
    .ack(bus_ack), .rdata(bus_rdata),
    .dev_addr(dev_addr_o), .dev_dq_o(dev_dq_o), .dev_dq_i(dev_dq_i),
    .ce_n(dev_ce_n_o), .we_n(dev_we_n_o), .oe_n(dev_oe_n_o)
  );

  bes_timer #(.W(TW)) u_tmr (
    .clk, .rst_n, .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // Bus requests and timer loads per phase
  always_comb begin
    bus_req   = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = CMD_READ;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (st)
      S_PP_CMD:   begin bus_req = 1'b1; bus_wdata = CMD_PROGRAM; end
      S_PP_DATA:  begin
        bus_req = 1'b1; bus_wdata = DATA_ZERO;
        tmr_load = bus_ack; tmr_val = TW'(PROG_CYC);
      end
      S_ER_SETUP: begin bus_req = 1'b1; bus_wdata = CMD_ERASE; end
      S_ER_GO:    begin
        bus_req = 1'b1; bus_wdata = CMD_ERASE;
        tmr_load = bus_ack; tmr_val = TW'(ERASE_CYC);
      end
      S_VF_CMD:   begin
        bus_req = 1'b1; bus_wdata = CMD_VERIFY;
        tmr_load = bus_ack; tmr_val = TW'(VERIFY_CYC);
      end
      S_VF_READ:  begin bus_req = 1'b1; bus_rd = 1'b1; end
      S_EXIT:     begin bus_req = 1'b1; bus_wdata = CMD_READ; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      pulse_q <= '0;
      vpp_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          st      <= S_PP_CMD;
          addr_q  <= '0;
          pulse_q <= '0;
          vpp_q   <= 1'b1;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        S_PP_CMD:  if (bus_ack) st <= S_PP_DATA;
        S_PP_DATA: if (bus_ack) st <= S_PP_WAIT;
        S_PP_WAIT: if (tmr_zero) begin
          if (addr_q == LAST_ADDR) begin
            addr_q <= '0;
            st     <= S_ER_SETUP;
          end else begin
            addr_q <= addr_q + 1'b1;
            st     <= S_PP_CMD;
          end
        end
        S_ER_SETUP: if (bus_ack) st <= S_ER_GO;
        S_ER_GO: if (bus_ack) begin
          pulse_q <= pulse_q + 1'b1;
          st      <= S_ER_WAIT;
        end
        S_ER_WAIT: if (tmr_zero) st <= S_VF_CMD;
        S_VF_CMD:  if (bus_ack)  st <= S_VF_WAIT;
        S_VF_WAIT: if (tmr_zero) st <= S_VF_READ;
        S_VF_READ: if (bus_ack) begin
          if (bus_rdata == DATA_ERASED) begin
            if (addr_q == LAST_ADDR) st <= S_EXIT;
            else begin
              addr_q <= addr_q + 1'b1;
              st     <= S_VF_CMD;
            end
          end else if (pulse_q == PW'(MAX_PULSES)) begin
            st     <= S_IDLE;
            vpp_q  <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st <= S_ER_SETUP;   // address held: resume here
          end
        end
        S_EXIT: if (bus_ack) begin
          st     <= S_IDLE;
          vpp_q  <= 1'b0;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vpp_en_o = vpp_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/bes_checks.sv
module bes_checks #(
  parameter int AW   = 8,
  parameter int PW   = 4,
  parameter int MAXP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          vpp_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    dq_o,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [PW-1:0] pulse_cnt
);

  p_we_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));

  p_oe_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  p_write_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> (we_n || ($stable(addr) && $stable(dq_o))));

  p_vpp_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> vpp_en);

  p_vpp_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vpp_en);

  p_err_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_pulse_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PW'(MAXP));

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vpp_en && ce_n));

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !err));

endmodule

bind bulk_erase_seq bes_checks #(.AW(ADDR_W), .PW(PW), .MAXP(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy),
  .done(done_o), .err(err_o), .vpp_en(vpp_en_o),
  .addr(dev_addr_o), .dq_o(dev_dq_o),
  .ce_n(dev_ce_n_o), .we_n(dev_we_n_o), .oe_n(dev_oe_n_o),
  .pulse_cnt(pulse_q)
);

// File: tb/bulk_erase_seq_tb.sv
module bulk_erase_seq_tb;
  localparam int AW    = 4;
  localparam int NB    = 1 << AW;
  localparam int PROG  = 3;
  localparam int ERASE = 20;
  localparam int VWAIT = 2;
  localparam int MAXP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, err_o, vpp_en_o;
  logic [AW-1:0] dev_addr_o;
  logic [7:0] dev_dq_o, dev_dq_i;
  logic dev_ce_n_o, dev_we_n_o, dev_oe_n_o;

  always #4 clk = ~clk;   // 125 MHz

  bulk_erase_seq #(.ADDR_W(AW), .PROG_CYC(PROG), .ERASE_CYC(ERASE),
                   .VERIFY_CYC(VWAIT), .MAX_PULSES(MAXP)) u_dut (
    .clk, .rst_n, .start_i, .done_o, .err_o, .vpp_en_o,
    .dev_addr_o, .dev_dq_o, .dev_dq_i,
    .dev_ce_n_o, .dev_we_n_o, .dev_oe_n_o
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  typedef enum {M_RD, M_PGM, M_ERS, M_VFY} mmode_e;
  mmode_e mode = M_RD;
  logic [7:0] mem [NB];
  int need [NB];
  int hits [NB];
  logic [AW-1:0] vaddr = '0;
  bit erasing = 0;
  bit first_erase = 1;
  int t_erase = 0;
  int t_verify = 0;

  assign dev_dq_i = (mode == M_VFY) ? mem[vaddr] : 8'h00;

  // ---------------- scoreboard ----------------
  typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  task automatic push(input int a, input logic [7:0] d);
    wr_t w;
    w.a = AW'(a); w.d = d;
    exp_q.push_back(w);
  endtask

  // Driver: expected write stream from R1, R2, R5, R6, R7
  task automatic build_expect(output bit exp_err);
    int e;
    int a;
    exp_err = 0;
    for (int i = 0; i < NB; i++) begin push(i, 8'h40); push(i, 8'h00); end
    push(0, 8'h20); push(0, 8'h20);
    e = 1;
    a = 0;
    while (a < NB) begin
      push(a, 8'hA0);
      if (e >= need[a]) a++;
      else if (e == MAXP) begin exp_err = 1; break; end
      else begin push(a, 8'h20); push(a, 8'h20); e++; end
    end
    if (!exp_err) push(NB - 1, 8'h00);
  endtask

  // Monitor: compare each device write, then update the model
  task automatic on_write(input logic [AW-1:0] a, input logic [7:0] d);
    wr_t w;
    check(vpp_en_o == 1'b1, "R8 vpp during write", vpp_en_o, 1);
    if (exp_q.size() == 0) begin
      check(0, "R7 unexpected write", {a, d}, 0);
    end else begin
      w = exp_q.pop_front();
      check(w.a == a && w.d == d, "R1/R2/R5 write order", {a, d}, {w.a, w.d});
    end
    if (erasing) begin
      erasing = 0;
      check(cyc - t_erase >= ERASE, "R3 erase pulse length", cyc - t_erase, ERASE);
    end
    case (mode)
      M_PGM: begin
        if (vpp_en_o) mem[a] = mem[a] & d;
        mode = M_RD;
      end
      M_ERS: begin
        mode = M_RD;
        if (d == 8'h20) begin
          if (first_erase) begin
            bit allz = 1;
            for (int i = 0; i < NB; i++) if (mem[i] != 8'h00) allz = 0;
            check(allz, "R1 array zero before erase", allz, 1);
            first_erase = 0;
          end
          if (vpp_en_o)
            for (int i = 0; i < NB; i++) begin
              hits[i]++;
              if (hits[i] >= need[i]) mem[i] = 8'hFF;
            end
          erasing = 1;
          t_erase = cyc;
        end
      end
      default: begin
        if (d == 8'h40) mode = M_PGM;
        else if (d == 8'h20) mode = M_ERS;
        else if (d == 8'hA0) begin mode = M_VFY; vaddr = a; t_verify = cyc; end
        else mode = M_RD;
      end
    endcase
  endtask

  always @(posedge dev_we_n_o) if (!dev_ce_n_o) on_write(dev_addr_o, dev_dq_o);

  always @(negedge dev_oe_n_o)
    if (rst_n) check(cyc - t_verify >= VWAIT, "R4 settle before read", cyc - t_verify, VWAIT);

  // ---------------- scenario runner ----------------
  task automatic run_case(input string name);
    bit exp_err;
    bit allff;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'(i * 37 + 5); hits[i] = 0; end
    mode = M_RD; erasing = 0; first_erase = 1;
    exp_q.delete();
    build_expect(exp_err);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(done_o == 1'b0 && err_o == 1'b0, "R6 start clears status", {done_o, err_o}, 0);
    check(vpp_en_o == 1'b1, "R8 vpp after start", vpp_en_o, 1);
    while (!done_o) @(negedge clk);
    check(exp_q.size() == 0, "R1/R5 all expected writes seen", exp_q.size(), 0);
    check(err_o == exp_err, "R6/R7 error flag", err_o, exp_err);
    check(vpp_en_o == 1'b0, "R6/R7 vpp dropped", vpp_en_o, 0);
    allff = 1;
    for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) allff = 0;
    if (!exp_err) check(allff, "R6 array erased", allff, 1);
    repeat (10) @(negedge clk);
    check(dev_ce_n_o == 1'b1, "R7 no writes after end", dev_ce_n_o, 1);
    $display("scenario %s done", name);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dev_ce_n_o && dev_we_n_o && dev_oe_n_o, "R10 bus idle in reset",
          {dev_ce_n_o, dev_we_n_o, dev_oe_n_o}, 3'b111);
    check(!done_o && !err_o && !vpp_en_o, "R10 status low in reset",
          {done_o, err_o, vpp_en_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // clean chip: one pulse erases everything
    for (int i = 0; i < NB; i++) need[i] = 1;
    run_case("clean");

    // slow bytes: re-erase and resume at addresses 5 and 9 (R5)
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[5] = 2; need[9] = 3;
    run_case("resume");

    // worn byte beyond the pulse limit (R7)
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[7] = MAXP + 2;
    run_case("limit");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

endmodule